// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time and a calendar inside a larger chip. A timebase enable (nominally 32.768 kHz) drives a sub-second prescaler. Each time the prescaler completes one second, the seconds, minutes and hours fields advance. A rollover of the hours field advances the date, the month, the year and an independent day-of-week counter. Every field is held in BCD. Hours run 00 to 23. The two-digit year 00 to 99 stands for 2000 to 2099, so a year is a leap year exactly when its value is divisible by 4.

A host reads and loads the fields through a synchronous register port. Loading a field also restarts the sub-second phase, so the next second boundary falls a full second after the load. A sticky clock-lost flag is raised at reset and by a power-up indication input. The flag stays set until the host loads a time field, so software can tell that the time is invalid. All time fields are also brought out in parallel for an alarm comparator.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds, minutes and hours read 00, date 01, month 01, year 00, day-of-week 0, and the clock-lost flag is 1.
- R2: Seconds advance by one on every TICKS_PER_SEC-th cycle with tick_i high, counted across gaps where tick_i is low. Seconds 59 wrap to 00 and advance minutes, and minutes 59 wrap to 00 and advance hours.
- R3: Hours 23 wrap to 00 and advance the date; hours below 23 advance without touching the date.
- R4: Months 01, 03, 05, 07, 08, 10, 12 (and any non-BCD month) have 31 days, and months 04, 06, 09, 11 have 30. After the last day the date becomes 01 and the month advances in BCD (09 to 10). Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R5: February has 29 days when the BCD year is divisible by 4 (00, 04 through 96) and 28 otherwise.
- R6: The day-of-week counts 0 to 6, advances whenever the date advances, and wraps from 6 to 0.
- R7: With wr_en_i high, addr_i selects the field: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day-of-week (wdata_i[2:0]). The value appears at the next clock edge. A write to address 0 to 6 clears the sub-second phase, and no field advances in that cycle.
- R8: With rd_en_i high, rdata_o shows the field at addr_i after the next clock edge. Day-of-week is zero-extended, and address 7 returns the clock-lost flag in bit 0. rdata_o holds its value while rd_en_i is low.
- R9: The clock-lost flag is set by pwr_up_i and stays set until a write to addresses 0 to 6. pwr_up_i wins over a write in the same cycle. A write to address 7 has no effect on any state.
- R10: A non-BCD value written by the host is stored as written. An increment turns a low digit of 9 or more into 0 with a carry into the high digit. A field wraps only from its exact maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase enable, one cycle per timebase period |
| pwr_up_i | input | 1 | Power-up indication, sets the clock-lost flag |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD 24-hour |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within century, BCD |
| dow_o | output | 3 | Day-of-week 0 to 6 |
| fail_o | output | 1 | Clock-lost flag |

## Verification
The hardest situations to reach from the ports are the rare calendar boundaries: the end of February in leap and non-leap years, the end of a 30-day month, and the end of a century. Counting up to them would take months of simulated seconds. The bench therefore loads every field through the write port to 23:59:59 on the day before each boundary. It then runs exactly one second, using a small TICKS_PER_SEC, and compares all seven fields. The sub-second phase is probed by loading a field partway through a second and showing that the next advance comes a full second later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned BCD_W  = 8;
  localparam int unsigned DOW_W  = 3;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_TOD  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEC   = 3'd0,
    REG_MIN   = 3'd1,
    REG_HOUR  = 3'd2,
    REG_DATE  = 3'd3,
    REG_MONTH = 3'd4,
    REG_YEAR  = 3'd5,
    REG_DOW   = 3'd6,
    REG_STAT  = 3'd7
  } rtc_reg_e;

  localparam logic [BCD_W-1:0] TOD_MAX [N_TOD] = '{8'h59, 8'h59, 8'h23};
  localparam logic [DOW_W-1:0] DOW_MAX = 3'd6;

  // low digit 9 or above carries; keeps counting from illegal codes
  function automatic logic [BCD_W-1:0] bcd_next(input logic [BCD_W-1:0] v);
    logic [3:0] hi;
    hi = v[7:4] + 4'd1;
    if (v[3:0] >= 4'd9) return {hi, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [BCD_W-1:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [BCD_W-1:0] last_day(input logic [BCD_W-1:0] mon,
                                                input logic [BCD_W-1:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_o
);

  localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign sec_o   = tick_i && at_last && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (tick_i)        cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // R7
  phase_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  // R2
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |=> (cnt_q == '0));

  // R2
  phase_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter
  import rtc_pkg::*;
#(
  parameter logic [BCD_W-1:0] MAX     = 8'h59,
  parameter logic [BCD_W-1:0] RST_VAL = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [BCD_W-1:0] ld_val_i,
  output logic [BCD_W-1:0] val_o,
  output logic             carry_o
);

  logic [BCD_W-1:0] val_q;
  logic             at_max;

  assign at_max  = (val_q == MAX);
  assign carry_o = inc_i && !ld_i && at_max;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST_VAL;
    else if (ld_i)   val_q <= ld_val_i;
    else if (inc_i)  val_q <= at_max ? '0 : bcd_next(val_q);
  end

  // R7
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (val_q == $past(ld_val_i)));

  // R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> (val_q == '0));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(val_q));

endmodule

// File: rtl/rtc_calendar_unit.sv
module rtc_calendar_unit
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             day_inc_i,
  input  logic             ld_date_i,
  input  logic             ld_month_i,
  input  logic             ld_year_i,
  input  logic             ld_dow_i,
  input  logic [BCD_W-1:0] wdata_i,
  output logic [BCD_W-1:0] date_o,
  output logic [BCD_W-1:0] month_o,
  output logic [BCD_W-1:0] year_o,
  output logic [DOW_W-1:0] dow_o
);

  logic [BCD_W-1:0] date_q, month_q, year_q;
  logic [DOW_W-1:0] dow_q;
  logic             date_wrap, month_wrap;

  assign date_wrap  = day_inc_i && !ld_date_i && (date_q == last_day(month_q, year_q));
  assign month_wrap = date_wrap && !ld_month_i && (month_q == 8'h12);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
      dow_q   <= '0;
    end else begin
      if (ld_date_i)       date_q <= wdata_i;
      else if (date_wrap)  date_q <= 8'h01;
      else if (day_inc_i)  date_q <= bcd_next(date_q);

      if (ld_month_i)      month_q <= wdata_i;
      else if (month_wrap) month_q <= 8'h01;
      else if (date_wrap)  month_q <= bcd_next(month_q);

      if (ld_year_i)       year_q <= wdata_i;
      else if (month_wrap) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_next(year_q);

      if (ld_dow_i)        dow_q <= wdata_i[DOW_W-1:0];
      else if (day_inc_i)  dow_q <= (dow_q == DOW_MAX) ? '0 : dow_q + 1'b1;
    end
  end

  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;
  assign dow_o   = dow_q;

  // R6
  dow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_inc_i && !ld_dow_i && dow_q == DOW_MAX) |=> (dow_q == '0));

  // R4
  month_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!day_inc_i && !ld_month_i) |=> $stable(month_q));

  // R4
  year_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!day_inc_i && !ld_year_i) |=> $stable(year_q));

  // R5
  leap_day_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_inc_i && !ld_date_i && month_q == 8'h02 && date_q == 8'h28 && year_q[1:0] == 2'b00
     && !year_q[4]) |=> (date_q == 8'h29));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwr_up_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BCD_W-1:0]  wdata_i,
  output logic [BCD_W-1:0]  rdata_o,
  output logic [BCD_W-1:0]  sec_o,
  output logic [BCD_W-1:0]  min_o,
  output logic [BCD_W-1:0]  hour_o,
  output logic [BCD_W-1:0]  date_o,
  output logic [BCD_W-1:0]  month_o,
  output logic [BCD_W-1:0]  year_o,
  output logic [DOW_W-1:0]  dow_o,
  output logic              fail_o
);

  localparam int unsigned N_FIELDS = 7;

  logic [N_FIELDS-1:0] ld;
  logic                time_wr;
  logic                sec_pulse;
  logic [N_TOD:0]      tod_inc;
  logic [BCD_W-1:0]    tod_val [N_TOD];
  logic                fail_q;
  logic [BCD_W-1:0]    rdata_q;

  always_comb begin
    for (int k = 0; k < N_FIELDS; k++) ld[k] = wr_en_i && (addr_i == ADDR_W'(k));
  end
  assign time_wr = |ld;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (time_wr),
    .sec_o  (sec_pulse)
  );

  assign tod_inc[0] = sec_pulse;

  for (genvar g = 0; g < N_TOD; g++) begin : g_tod
    rtc_bcd_counter #(.MAX(TOD_MAX[g]), .RST_VAL(8'h00)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (tod_inc[g]),
      .ld_i     (ld[g]),
      .ld_val_i (wdata_i),
      .val_o    (tod_val[g]),
      .carry_o  (tod_inc[g+1])
    );
  end

  rtc_calendar_unit u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .day_inc_i  (tod_inc[N_TOD]),
    .ld_date_i  (ld[REG_DATE]),
    .ld_month_i (ld[REG_MONTH]),
    .ld_year_i  (ld[REG_YEAR]),
    .ld_dow_i   (ld[REG_DOW]),
    .wdata_i    (wdata_i),
    .date_o     (date_o),
    .month_o    (month_o),
    .year_o     (year_o),
    .dow_o      (dow_o)
  );

  assign sec_o  = tod_val[REG_SEC];
  assign min_o  = tod_val[REG_MIN];
  assign hour_o = tod_val[REG_HOUR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fail_q <= 1'b1;
    else if (pwr_up_i) fail_q <= 1'b1;
    else if (time_wr)  fail_q <= 1'b0;
  end
  assign fail_o = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) begin
      case (rtc_reg_e'(addr_i))
        REG_SEC:   rdata_q <= sec_o;
        REG_MIN:   rdata_q <= min_o;
        REG_HOUR:  rdata_q <= hour_o;
        REG_DATE:  rdata_q <= date_o;
        REG_MONTH: rdata_q <= month_o;
        REG_YEAR:  rdata_q <= year_o;
        REG_DOW:   rdata_q <= {{(BCD_W-DOW_W){1'b0}}, dow_o};
        default:   rdata_q <= {{(BCD_W-1){1'b0}}, fail_q};
      endcase
    end
  end
  assign rdata_o = rdata_q;

  // R9
  fail_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_up_i |=> fail_o);

  // R9
  fail_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != REG_STAT && !pwr_up_i) |=> !fail_o);

  // R8
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  // R7
  no_adv_on_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != REG_SEC && addr_i != REG_STAT) |=> $stable(sec_o));

  // R9
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_STAT && !pwr_up_i) |=> (fail_o == $past(fail_o)));

endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  import rtc_pkg::*;

  localparam int unsigned TPS = 4;

  typedef struct packed {
    logic [7:0] s, m, h, d, mo, y;
    logic [2:0] w;
    logic [7:0] n;
    logic [7:0] es, em, eh, ed, emo, ey;
    logic [2:0] ew;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0,8'd1, 8'h01,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0,"R2"},
    '{8'h59,8'h34,8'h12,8'h15,8'h06,8'h25,3'd3,8'd1, 8'h00,8'h35,8'h12,8'h15,8'h06,8'h25,3'd3,"R2"},
    '{8'h58,8'h59,8'h09,8'h05,8'h07,8'h30,3'd2,8'd3, 8'h01,8'h00,8'h10,8'h05,8'h07,8'h30,3'd2,"R2"},
    '{8'h59,8'h59,8'h22,8'h10,8'h03,8'h30,3'd0,8'd1, 8'h00,8'h00,8'h23,8'h10,8'h03,8'h30,3'd0,"R3"},
    '{8'h59,8'h59,8'h23,8'h31,8'h01,8'h24,3'd6,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h02,8'h24,3'd0,"R3"},
    '{8'h59,8'h59,8'h23,8'h30,8'h04,8'h10,3'd1,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h05,8'h10,3'd2,"R4"},
    '{8'h59,8'h59,8'h23,8'h30,8'h09,8'h00,3'd0,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h10,8'h00,3'd1,"R4"},
    '{8'h59,8'h59,8'h23,8'h31,8'h12,8'h99,3'd5,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,3'd6,"R4"},
    '{8'h59,8'h59,8'h23,8'h30,8'h12,8'h41,3'd3,8'd1, 8'h00,8'h00,8'h00,8'h31,8'h12,8'h41,3'd4,"R4"},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h24,3'd2,8'd1, 8'h00,8'h00,8'h00,8'h29,8'h02,8'h24,3'd3,"R5"},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h23,3'd2,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h23,3'd3,"R5"},
    '{8'h59,8'h59,8'h23,8'h29,8'h02,8'h24,3'd4,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h24,3'd5,"R5"},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h00,3'd1,8'd1, 8'h00,8'h00,8'h00,8'h29,8'h02,8'h00,3'd2,"R5"},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h96,3'd1,8'd1, 8'h00,8'h00,8'h00,8'h29,8'h02,8'h96,3'd2,"R5"},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h98,3'd1,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h98,3'd2,"R5"},
    '{8'h59,8'h59,8'h23,8'h09,8'h01,8'h50,3'd6,8'd1, 8'h00,8'h00,8'h00,8'h10,8'h01,8'h50,3'd0,"R6"},
    '{8'h5A,8'h00,8'h07,8'h01,8'h01,8'h00,3'd0,8'd1, 8'h60,8'h00,8'h07,8'h01,8'h01,8'h00,3'd0,"R10"}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       pwr_up_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic [2:0] dow_o;
  logic       fail_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  rtc_calendar #(.TICKS_PER_SEC(TPS)) u_rtc_calendar (
    .clk_i, .rst_ni, .tick_i, .pwr_up_i, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .rdata_o, .sec_o, .min_o, .hour_o, .date_o, .month_o, .year_o, .dow_o, .fail_o
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  function automatic logic [50:0] now();
    return {sec_o, min_o, hour_o, date_o, month_o, year_o, dow_o};
  endfunction

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(64'(now()), 64'({8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 3'd0}), "R1 fields");
    chk(64'(fail_o), 64'd1, "R1 flag");

    // R8 status read, R9 status write ignored
    rd(REG_STAT, r);
    chk(64'(r), 64'h01, "R8 status read");
    wr(REG_STAT, 8'h00);
    chk(64'(fail_o), 64'd1, "R9 status write ignored");
    chk(64'(now()), 64'({8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 3'd0}), "R9 status write no state change");

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(REG_SEC,   VECS[i].s);
      wr(REG_MIN,   VECS[i].m);
      wr(REG_HOUR,  VECS[i].h);
      wr(REG_DATE,  VECS[i].d);
      wr(REG_MONTH, VECS[i].mo);
      wr(REG_YEAR,  VECS[i].y);
      wr(REG_DOW,   {5'd0, VECS[i].w});
      ticks(int'(VECS[i].n) * TPS);
      chk(64'(now()), 64'({VECS[i].es, VECS[i].em, VECS[i].eh, VECS[i].ed,
                           VECS[i].emo, VECS[i].ey, VECS[i].ew}),
          $sformatf("%s vector %0d", VECS[i].tag, i));
    end

    // R9 write cleared flag
    chk(64'(fail_o), 64'd0, "R9 cleared by write");

    // R8 reads of fields; last vector left 00:00:07 ... sec 60
    rd(REG_SEC, r);
    chk(64'(r), 64'h60, "R8 read sec");
    rd(REG_HOUR, r);
    chk(64'(r), 64'h07, "R8 read hour");
    wr(REG_SEC, 8'h33);
    chk(64'(rdata_o), 64'h07, "R8 rdata holds");

    // R7 phase cleared by write
    wr(REG_SEC, 8'h10);
    ticks(TPS - 2);
    wr(REG_SEC, 8'h20);
    ticks(TPS - 1);
    chk(64'(sec_o), 64'h20, "R7 phase restarted");
    ticks(1);
    chk(64'(sec_o), 64'h21, "R2 full second after load");

    // R2 ticks counted across gaps
    ticks(2);
    repeat (5) @(negedge clk_i);
    chk(64'(sec_o), 64'h21, "R2 partial second");
    ticks(TPS - 2);
    chk(64'(sec_o), 64'h22, "R2 gap counting");

    // R7 write during tick: no advance that cycle
    tick_i = 1'b1;
    wr(REG_MIN, 8'h45);
    tick_i = 1'b0;
    chk(64'({sec_o, min_o}), 64'({8'h22, 8'h45}), "R7 load with tick");

    // R9 power-up flag
    @(negedge clk_i); pwr_up_i = 1'b1;
    @(negedge clk_i); pwr_up_i = 1'b0;
    chk(64'(fail_o), 64'd1, "R9 set by pwr_up");
    @(negedge clk_i);
    pwr_up_i = 1'b1; wr_en_i = 1'b1; addr_i = REG_MIN; wdata_i = 8'h46;
    @(negedge clk_i);
    pwr_up_i = 1'b0; wr_en_i = 1'b0;
    chk(64'(fail_o), 64'd1, "R9 pwr_up wins");
    wr(REG_MIN, 8'h47);
    chk(64'(fail_o), 64'd0, "R9 cleared again");

    // R7 dow uses low bits, R8 zero-extended read
    wr(REG_DOW, 8'hFD);
    chk(64'(dow_o), 64'd5, "R7 dow load");
    rd(REG_DOW, r);
    chk(64'(r), 64'h05, "R8 dow read");

    // R10 illegal hour stored, counts on
    wr(REG_HOUR, 8'h2F);
    chk(64'(hour_o), 64'h2F, "R10 illegal stored");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule